// File: doc/BRIEF.md
# Power-Fail Interrupt and Reset Sequencer

This block is a fully digital stand-in for an analog supply monitor. It takes a power-good level that has already been cleaned up, and it drives two active-low lines to the processor: a non-maskable interrupt and a reset. When the supply drops, the interrupt goes active at once, which gives software a window to save its state. After a fixed warning interval, reset is asserted and then held. If the supply only sagged and has since come back, both lines are released at a fixed time after the interrupt first fired. The processor then starts again as it would after a cold power cycle.

At power-up, the power-good level must first stay high for a qualification interval. The block then holds reset for a further settling interval before it releases it. A falling power-good is acted on immediately, while a rising one must persist before it counts. This asymmetry is the digital form of separate turn-on and turn-off thresholds. All intervals are parameters given in clock cycles.

Top module: `pwr_fail_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, `cpu_rst_no` is 0 and `nmi_no` is 1. The block then waits for power-good.
- R2: Starting from the reset-held state, let edge k be the first clock edge at which `pwr_good_i` is sampled high, and suppose it stays high. Then `cpu_rst_no` is still 0 after edge k+1+QUAL_CYC+SETTLE_CYC and becomes 1 at edge k+2+QUAL_CYC+SETTLE_CYC. `nmi_no` stays 1 throughout.
- R3: In the running state, let edge k be the first edge at which `pwr_good_i` is sampled low. Then `nmi_no` is still 1 after edge k+1 and becomes 0 at edge k+2, while `cpu_rst_no` is still 1.
- R4: `cpu_rst_no` falls exactly WARN_CYC cycles after `nmi_no` falls.
- R5: If power-good is qualified high when RESTART_CYC cycles have passed since `nmi_no` fell, both `cpu_rst_no` and `nmi_no` return to 1 on that edge.
- R6: If power-good is low at that same point, `nmi_no` returns to 1 but `cpu_rst_no` stays 0. The block then follows the power-up sequence of R2.
- R7: A high pulse on `pwr_good_i` that lasts fewer than QUAL_CYC cycles, arriving while reset is held, never releases `cpu_rst_no`.
- R8: If power-good drops during the settling interval, reset stays asserted and the whole power-up timing of R2 starts over from the next rise.
- R9: `nmi_no` never rises on an edge where `cpu_rst_no` was 1 before that edge.
- R10: Once `nmi_no` has fallen, a return of power-good during the warning interval does not cancel the sequence. Reset still asserts after WARN_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high clear; forces reset-held state |
| pwr_good_i | input | 1 | Clean power-good level, asynchronous to `clk` |
| nmi_no | output | 1 | Non-maskable interrupt to processor, active low |
| cpu_rst_no | output | 1 | Processor reset, active low |

## Verification
A sequencer stuck in the wrong phase shows up at the ports as an output edge in the wrong place, because both outputs come straight from the phase register.

- A warning counter that is off by one moves the fall of `cpu_rst_no` by one cycle relative to the fall of `nmi_no`.
- A phase that skips the warning interval makes both lines fall on the same edge.
- A qualification filter that resets wrongly either releases reset after a short glitch or shifts the power-up release edge.

Each of these faults is visible within one sequence interval, so every check compares the exact edge on which a line changes.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        PS_OFF    = 3'd0,   // reset held, waiting for power-good
        PS_SETTLE = 3'd1,   // power-good qualified, settling count
        PS_RUN    = 3'd2,   // processor running
        PS_WARN   = 3'd3,   // interrupt raised, reset not yet asserted
        PS_HOLD   = 3'd4    // interrupt and reset both asserted
    } ps_state_e;

    // Drive levels of the two processor lines (active low)
    typedef struct packed {
        logic irq_n;
        logic hold_n;
    } ps_drive_t;

    function automatic int unsigned ps_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic ps_drive_t ps_decode(input ps_state_e s);
        ps_drive_t d;
        case (s)
            PS_RUN:  begin d.irq_n = 1'b1; d.hold_n = 1'b1; end
            PS_WARN: begin d.irq_n = 1'b0; d.hold_n = 1'b1; end
            PS_HOLD: begin d.irq_n = 1'b0; d.hold_n = 1'b0; end
            default: begin d.irq_n = 1'b1; d.hold_n = 1'b0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwrseq_qual.sv
// Asymmetric filter: a low level passes at once, a high level
// must persist QUAL_CYC cycles before it is accepted.
module pwrseq_qual #(
    parameter int unsigned QUAL_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic good_o
);
    localparam int unsigned QW = $clog2(QUAL_CYC + 1);
    localparam logic [QW-1:0] QLAST = QW'(QUAL_CYC - 1);

    logic [QW-1:0] run_q;
    logic          ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            ok_q  <= 1'b0;
        end else if (!lvl_i) begin
            run_q <= '0;
            ok_q  <= 1'b0;
        end else if (!ok_q) begin
            if (run_q == QLAST) ok_q  <= 1'b1;
            else                run_q <= run_q + 1'b1;
        end
    end

    assign good_o = lvl_i & ok_q;
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int unsigned WARN_CYC    = 1_000_000,
    parameter int unsigned RESTART_CYC = 26_000_000,
    parameter int unsigned SETTLE_CYC  = 10_000_000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      good_i,
    output ps_drive_t drv_o
);
    localparam int unsigned CW = $clog2(ps_max(RESTART_CYC, SETTLE_CYC) + 1);
    localparam logic [CW-1:0] WLAST = CW'(WARN_CYC - 1);
    localparam logic [CW-1:0] RLAST = CW'(RESTART_CYC - 1);
    localparam logic [CW-1:0] SLAST = CW'(SETTLE_CYC - 1);

    ps_state_e     st_q, st_nx;
    logic [CW-1:0] cnt_q, cnt_nx;
    ps_drive_t     drv_q;

    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        case (st_q)
            PS_OFF: begin
                cnt_nx = '0;
                if (good_i) st_nx = PS_SETTLE;
            end
            PS_SETTLE: begin
                if (!good_i) begin
                    st_nx  = PS_OFF;
                    cnt_nx = '0;
                end else if (cnt_q == SLAST) begin
                    st_nx  = PS_RUN;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            PS_RUN: begin
                cnt_nx = '0;
                if (!good_i) st_nx = PS_WARN;
            end
            PS_WARN: begin
                cnt_nx = cnt_q + 1'b1;
                if (cnt_q == WLAST) st_nx = PS_HOLD;
            end
            PS_HOLD: begin
                if (cnt_q == RLAST) begin
                    st_nx  = good_i ? PS_RUN : PS_OFF;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            default: begin
                st_nx  = PS_OFF;
                cnt_nx = '0;
            end
        endcase
    end

    // Outputs registered from the next phase: same timing as the
    // phase register, no decode glitches on the processor lines.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_OFF;
            cnt_q <= '0;
            drv_q <= ps_decode(PS_OFF);
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
            drv_q <= ps_decode(st_nx);
        end
    end

    assign drv_o = drv_q;
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq
    import pwrseq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_CYC    = 1_000,
    parameter int unsigned WARN_CYC    = 1_000_000,
    parameter int unsigned RESTART_CYC = 26_000_000,
    parameter int unsigned SETTLE_CYC  = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good_i,
    output logic nmi_no,
    output logic cpu_rst_no
);
    logic      lvl_sync;
    logic      good_q;
    ps_drive_t drv;

    pwrseq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (pwr_good_i),
        .q_o (lvl_sync)
    );

    pwrseq_qual #(.QUAL_CYC(QUAL_CYC)) qual_i (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl_sync),
        .good_o (good_q)
    );

    pwrseq_fsm #(
        .WARN_CYC    (WARN_CYC),
        .RESTART_CYC (RESTART_CYC),
        .SETTLE_CYC  (SETTLE_CYC)
    ) fsm_i (
        .clk    (clk),
        .rst    (rst),
        .good_i (good_q),
        .drv_o  (drv)
    );

    assign nmi_no     = drv.irq_n;
    assign cpu_rst_no = drv.hold_n;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
    input logic clk,
    input logic rst,
    input logic pwr_good_i,
    input logic nmi_no,
    input logic cpu_rst_no
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!cpu_rst_no && nmi_no));

    // R3
    nmi_fall_run_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_no) |-> cpu_rst_no);

    // R3
    nmi_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_no) |-> !$past(pwr_good_i, 2));

    // R4
    rst_after_nmi_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst_no) |-> !nmi_no);

    // R5
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_rst_no) |-> nmi_no);

    // R9
    nmi_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_no) |-> !$past(cpu_rst_no));
endmodule

bind pwr_fail_seq pwrseq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .pwr_good_i (pwr_good_i),
    .nmi_no     (nmi_no),
    .cpu_rst_no (cpu_rst_no)
);

// File: tb/pwr_fail_seq_tb.sv
module pwr_fail_seq_tb_top;
    localparam int unsigned QUAL    = 5;
    localparam int unsigned WARN    = 20;
    localparam int unsigned RESTART = 60;
    localparam int unsigned SETTLE  = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pg  = 1'b0;
    logic nmi_n;
    logic rst_n;

    int n_chk  = 0;
    int n_fail = 0;
    int r9_bad = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwr_fail_seq #(
        .SYNC_STAGES (2),
        .QUAL_CYC    (QUAL),
        .WARN_CYC    (WARN),
        .RESTART_CYC (RESTART),
        .SETTLE_CYC  (SETTLE)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .pwr_good_i (pg),
        .nmi_no     (nmi_n),
        .cpu_rst_no (rst_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // R9 monitor: interrupt never released while processor was running
    logic prev_rst_n = 1'b0;
    logic prev_nmi_n = 1'b1;
    always @(posedge clk) begin
        #2;
        if (!rst && nmi_n && !prev_nmi_n && prev_rst_n) r9_bad++;
        prev_rst_n = rst_n;
        prev_nmi_n = nmi_n;
    end

    task automatic t_reset();
        rst = 1'b1;
        pg  = 1'b0;
        tick(3);
        check("R1 rst held", rst_n, 1'b0);
        check("R1 nmi idle", nmi_n, 1'b1);
        rst = 1'b0;
        tick(1);
        check("R1 rst after clear", rst_n, 1'b0);
        check("R1 nmi after clear", nmi_n, 1'b1);
    endtask

    task automatic t_powerup(input string tag);
        pg = 1'b1;
        tick(1);                       // edge k
        tick(QUAL + SETTLE + 1);       // edge k+1+Q+S
        check({tag, " rst still low"}, rst_n, 1'b0);
        check({tag, " nmi idle"}, nmi_n, 1'b1);
        tick(1);                       // edge k+2+Q+S
        check({tag, " rst released"}, rst_n, 1'b1);
        check({tag, " nmi idle at release"}, nmi_n, 1'b1);
    endtask

    task automatic t_sag();
        pg = 1'b0;
        tick(1);                       // edge k
        tick(1);
        check("R3 nmi not yet", nmi_n, 1'b1);
        tick(1);                       // edge k+2
        check("R3 nmi active", nmi_n, 1'b0);
        check("R3 rst still released", rst_n, 1'b1);
        pg = 1'b1;                     // supply returns during warning
        tick(WARN - 1);
        check("R4 rst before warn end", rst_n, 1'b1);
        tick(1);
        check("R4 R10 rst asserted", rst_n, 1'b0);
        check("R4 nmi held", nmi_n, 1'b0);
        tick(RESTART - WARN - 1);
        check("R5 rst before restart", rst_n, 1'b0);
        check("R5 nmi before restart", nmi_n, 1'b0);
        tick(1);
        check("R5 rst restart", rst_n, 1'b1);
        check("R5 nmi restart", nmi_n, 1'b1);
    endtask

    task automatic t_loss();
        pg = 1'b0;
        tick(3);
        check("R6 nmi active", nmi_n, 1'b0);
        tick(RESTART - 1);
        check("R6 nmi before timeout", nmi_n, 1'b0);
        tick(1);
        check("R6 nmi released", nmi_n, 1'b1);
        check("R6 rst kept", rst_n, 1'b0);
        tick(QUAL + SETTLE + 5);
        check("R6 rst kept while power low", rst_n, 1'b0);
    endtask

    task automatic t_glitch();
        int bad = 0;
        pg = 1'b1;
        tick(QUAL - 1);
        pg = 1'b0;
        for (int i = 0; i < int'(QUAL + SETTLE + 10); i++) begin
            tick(1);
            if (rst_n !== 1'b0) bad++;
        end
        n_chk++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL R7 short pulse: got %0d released cycles expected 0", bad);
        end
    endtask

    task automatic t_settle_drop();
        pg = 1'b1;
        tick(QUAL + 2 + SETTLE / 2);
        pg = 1'b0;
        tick(4);
        check("R8 rst low after drop", rst_n, 1'b0);
        t_powerup("R8");
    endtask

    initial begin
        t_reset();
        t_powerup("R2");
        t_sag();
        t_loss();
        t_glitch();
        t_settle_drop();
        tick(5);
        n_chk++;
        if (r9_bad != 0) begin
            n_fail++;
            $display("FAIL R9 nmi rose while running: got %0d expected 0", r9_bad);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule